// File: doc/BRIEF.md
# Paired Gather Load Coalescer

This unit sits between a vector gather operation and a two-ported data cache. A gather names eight 64-bit element addresses and an active-element mask. The unit groups the elements into four fixed pairs: each even-indexed element with the odd-indexed element above it. When both members of a pair lie in the same 128-byte aligned block, it issues one cache access that carries the block address and two word offsets. Otherwise each element gets its own access. With only single accesses, an eight-element gather needs eight accesses. With merging it can need as few as four, so a gather takes two issue cycles instead of four.

Accesses go out at most two per cycle, one per cache port, in pair order. The cache answers each access exactly one cycle later with up to two 64-bit words. The unit places each word into the destination lane of the element that asked for it. Inactive lanes are filled with zero. The full 512-bit result is signalled with a one-cycle completion pulse. A new gather is accepted through a ready/valid handshake, and only when the previous one has finished.

Top module: `pair_gather_merge`

## Requirements
- R1: After reset, `req_ready` is 1, `acc_valid` is 0 on both ports and `out_valid` is 0.
- R2: Element addresses are 8-byte aligned. The block of an address is bits 63:7 and its word offset is bits 6:3. When both elements of a pair (2k, 2k+1) are active and their bits 63:7 are equal, exactly one access is issued for the pair, with `acc_two`=1, `acc_word0` = word offset of the even element and `acc_word1` = word offset of the odd element.
- R3: When both elements of a pair are active but their blocks differ, two accesses with `acc_two`=0 are issued for the pair, the even element first, each carrying its own block and its word offset in `acc_word0`.
- R4: A pair with one active element issues one access with `acc_two`=0 for that element. A pair with no active element issues no access.
- R5: Accesses are issued in ascending pair order, at most two per cycle. Port 0 carries the older one, and port 1 is never used without port 0. A gather needing n accesses keeps the ports busy for exactly ceil(n/2) cycles.
- R6: The data returned one cycle after an access (`rsp_data0` for the first offset, `rsp_data1` for the second) is written into the destination lane of the element that requested it.
- R7: Lanes whose mask bit is 0 read as zero in `out_data`.
- R8: `out_valid` is a one-cycle pulse. It appears ceil(n/2)+2 cycles after the accepting clock edge when n>0, and 1 cycle after it when n=0. `out_data` holds the result until the next gather is accepted.
- R9: `req_ready` is 1 only while no gather is in progress. A gather is taken on a clock edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Gather request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_addr | input | 512 | Eight element addresses, element i at bits 64i+63:64i |
| req_mask | input | 8 | Active-element mask, bit i for element i |
| acc_valid | output | 2 | Access valid, one bit per cache port |
| acc_block | output | 114 | Block address (bits 63:7) per port, port p at 57p |
| acc_word0 | output | 8 | First word offset per port, 4 bits each |
| acc_word1 | output | 8 | Second word offset per port, 4 bits each |
| acc_two | output | 2 | Access serves two elements, per port |
| rsp_valid | input | 2 | Cache answer valid, per port, one cycle after the access |
| rsp_data0 | input | 128 | Word for the first offset, 64 bits per port |
| rsp_data1 | input | 128 | Word for the second offset, 64 bits per port |
| out_valid | output | 1 | Gather complete pulse |
| out_data | output | 512 | Gathered result, lane i at bits 64i+63:64i |

## Verification
In the middle of a gather, one cycle carries two jobs at once. The unit issues the next pair of cache accesses while it writes the answers to the previous pair into their lanes. Only gathers that need three or more accesses create that overlap. The sweep runs every mask against address patterns that merge or split each pair on its own, so the overlap occurs with every mix of merged and split accesses. The bench judges it in two ways. It compares every issued access, in order, against a list it builds from block arithmetic. It then checks every lane of the final result against a data function of the address.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    localparam int ADDR_W      = 64;
    localparam int N_ELEM      = 8;
    localparam int WORD_BYTES  = 8;
    localparam int BLOCK_BYTES = 128;
    localparam int PORTS       = 2;

    localparam int WORD_LSB = $clog2(WORD_BYTES);
    localparam int BLK_LSB  = $clog2(BLOCK_BYTES);
    localparam int WSEL_W   = BLK_LSB - WORD_LSB;
    localparam int BLK_W    = ADDR_W - BLK_LSB;
    localparam int WADDR_W  = ADDR_W - WORD_LSB;
    localparam int LANE_W   = $clog2(N_ELEM);
    localparam int N_PAIR   = N_ELEM / 2;
    localparam int SLOT_W   = $clog2(N_ELEM + 1);
    localparam int DATA_W   = WORD_BYTES * 8;

    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [WSEL_W-1:0] w0;
        logic [WSEL_W-1:0] w1;
        logic [LANE_W-1:0] l0;
        logic [LANE_W-1:0] l1;
        logic              two;
    } acc_t;

    typedef struct packed {
        logic [LANE_W-1:0] l0;
        logic [LANE_W-1:0] l1;
        logic              two;
    } lane_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_DRAIN = 2'd2,
        S_FIN   = 2'd3
    } fsm_t;

    function automatic logic [BLK_W-1:0] blk_of(input logic [WADDR_W-1:0] wa);
        return wa[WADDR_W-1:WSEL_W];
    endfunction

    function automatic logic [WSEL_W-1:0] wsel_of(input logic [WADDR_W-1:0] wa);
        return wa[WSEL_W-1:0];
    endfunction

    function automatic acc_t solo(input logic [WADDR_W-1:0] wa, input logic [LANE_W-1:0] lane);
        acc_t a;
        a     = '0;
        a.blk = blk_of(wa);
        a.w0  = wsel_of(wa);
        a.l0  = lane;
        return a;
    endfunction

endpackage

// File: rtl/pgm_pair_split.sv
module pgm_pair_split
    import pgm_pkg::*;
#(
    parameter int PAIR = 0
) (
    input  logic [WADDR_W-1:0] wa_even,
    input  logic [WADDR_W-1:0] wa_odd,
    input  logic               act_even,
    input  logic               act_odd,
    output acc_t               acc_a,
    output acc_t               acc_b,
    output logic [1:0]         cnt
);

    localparam logic [LANE_W-1:0] LANE_E = LANE_W'(2 * PAIR);
    localparam logic [LANE_W-1:0] LANE_O = LANE_W'(2 * PAIR + 1);

    logic share;
    assign share = (blk_of(wa_even) == blk_of(wa_odd));

    always_comb begin
        acc_a = '0;
        acc_b = '0;
        cnt   = 2'd0;
        unique case ({act_even, act_odd})
            2'b11: begin
                if (share) begin
                    acc_a.blk = blk_of(wa_even);
                    acc_a.w0  = wsel_of(wa_even);
                    acc_a.w1  = wsel_of(wa_odd);
                    acc_a.l0  = LANE_E;
                    acc_a.l1  = LANE_O;
                    acc_a.two = 1'b1;
                    cnt       = 2'd1;
                end else begin
                    acc_a = solo(wa_even, LANE_E);
                    acc_b = solo(wa_odd, LANE_O);
                    cnt   = 2'd2;
                end
            end
            2'b10: begin
                acc_a = solo(wa_even, LANE_E);
                cnt   = 2'd1;
            end
            2'b01: begin
                acc_a = solo(wa_odd, LANE_O);
                cnt   = 2'd1;
            end
            default: cnt = 2'd0;
        endcase
    end

endmodule

// File: rtl/pgm_slot_pack.sv
module pgm_slot_pack
    import pgm_pkg::*;
(
    input  acc_t              cand_a [N_PAIR],
    input  acc_t              cand_b [N_PAIR],
    input  logic [1:0]        cand_n [N_PAIR],
    output acc_t              slot   [N_ELEM],
    output logic [SLOT_W-1:0] total
);

    logic [SLOT_W-1:0] base [N_PAIR];

    always_comb begin
        logic [SLOT_W-1:0] run;
        run = '0;
        for (int k = 0; k < N_PAIR; k++) begin
            base[k] = run;
            run     = run + SLOT_W'(cand_n[k]);
        end
        total = run;
    end

    always_comb begin
        for (int s = 0; s < N_ELEM; s++) begin
            slot[s] = '0;
            for (int k = 0; k < N_PAIR; k++) begin
                if (cand_n[k] != 2'd0 && base[k] == SLOT_W'(s))
                    slot[s] = cand_a[k];
                if (cand_n[k] == 2'd2 && (base[k] + SLOT_W'(1)) == SLOT_W'(s))
                    slot[s] = cand_b[k];
            end
        end
    end

endmodule

// File: rtl/pgm_lane_steer.sv
module pgm_lane_steer
    import pgm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic [N_ELEM-1:0]         clr_mask,
    input  logic [PORTS-1:0]          rsp_valid,
    input  lane_t                     fl [PORTS],
    input  logic [PORTS*DATA_W-1:0]   rsp_data0,
    input  logic [PORTS*DATA_W-1:0]   rsp_data1,
    output logic [N_ELEM*DATA_W-1:0]  result,
    output logic [N_ELEM-1:0]         resolved
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            resolved <= '0;
        end else if (clear) begin
            result   <= '0;
            resolved <= ~clr_mask;
        end else begin
            for (int p = 0; p < PORTS; p++) begin
                if (rsp_valid[p]) begin
                    result[fl[p].l0*DATA_W +: DATA_W] <= rsp_data0[p*DATA_W +: DATA_W];
                    resolved[fl[p].l0]                <= 1'b1;
                    if (fl[p].two) begin
                        result[fl[p].l1*DATA_W +: DATA_W] <= rsp_data1[p*DATA_W +: DATA_W];
                        resolved[fl[p].l1]                <= 1'b1;
                    end
                end
            end
        end
    end

    // R6: every answer lands in a lane that is still waiting for it
    for (genvar p = 0; p < PORTS; p++) begin : g_chk
        p_single_write_r6: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid[p] && !clear) |-> !resolved[fl[p].l0]);
    end

endmodule

// File: rtl/pair_gather_merge.sv
module pair_gather_merge
    import pgm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [N_ELEM*ADDR_W-1:0]  req_addr,
    input  logic [N_ELEM-1:0]         req_mask,
    output logic [PORTS-1:0]          acc_valid,
    output logic [PORTS*BLK_W-1:0]    acc_block,
    output logic [PORTS*WSEL_W-1:0]   acc_word0,
    output logic [PORTS*WSEL_W-1:0]   acc_word1,
    output logic [PORTS-1:0]          acc_two,
    input  logic [PORTS-1:0]          rsp_valid,
    input  logic [PORTS*DATA_W-1:0]   rsp_data0,
    input  logic [PORTS*DATA_W-1:0]   rsp_data1,
    output logic                      out_valid,
    output logic [N_ELEM*DATA_W-1:0]  out_data
);

    acc_t              cand_a [N_PAIR];
    acc_t              cand_b [N_PAIR];
    logic [1:0]        cand_n [N_PAIR];
    acc_t              slot_d [N_ELEM];
    logic [SLOT_W-1:0] total_d;

    acc_t              slot_q [N_ELEM];
    logic [SLOT_W-1:0] total_q;
    logic [SLOT_W-1:0] ptr_q;
    fsm_t              state_q;
    logic              accept;

    acc_t              cur  [PORTS];
    logic [PORTS-1:0]  cur_v;
    lane_t             fl_q [PORTS];
    logic [N_ELEM-1:0] resolved;

    for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
        pgm_pair_split #(.PAIR(g)) u_split (
            .wa_even  (req_addr[(2*g)*ADDR_W + WORD_LSB +: WADDR_W]),
            .wa_odd   (req_addr[(2*g+1)*ADDR_W + WORD_LSB +: WADDR_W]),
            .act_even (req_mask[2*g]),
            .act_odd  (req_mask[2*g+1]),
            .acc_a    (cand_a[g]),
            .acc_b    (cand_b[g]),
            .cnt      (cand_n[g])
        );
    end

    pgm_slot_pack u_pack (
        .cand_a (cand_a),
        .cand_b (cand_b),
        .cand_n (cand_n),
        .slot   (slot_d),
        .total  (total_d)
    );

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign out_valid = (state_q == S_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            ptr_q   <= '0;
            total_q <= '0;
            for (int s = 0; s < N_ELEM; s++) slot_q[s] <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (accept) begin
                    slot_q  <= slot_d;
                    total_q <= total_d;
                    ptr_q   <= '0;
                    state_q <= (total_d == '0) ? S_FIN : S_ISSUE;
                end
                S_ISSUE: begin
                    ptr_q <= ptr_q + SLOT_W'(PORTS);
                    if ((ptr_q + SLOT_W'(PORTS)) >= total_q) state_q <= S_DRAIN;
                end
                S_DRAIN: state_q <= S_FIN;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        logic [SLOT_W-1:0] idx;
        for (int p = 0; p < PORTS; p++) begin
            idx      = ptr_q + SLOT_W'(p);
            cur_v[p] = (state_q == S_ISSUE) && (idx < total_q);
            cur[p]   = cur_v[p] ? slot_q[idx[LANE_W-1:0]] : '0;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign acc_valid[p]                     = cur_v[p];
        assign acc_block[p*BLK_W +: BLK_W]      = cur[p].blk;
        assign acc_word0[p*WSEL_W +: WSEL_W]    = cur[p].w0;
        assign acc_word1[p*WSEL_W +: WSEL_W]    = cur[p].w1;
        assign acc_two[p]                       = cur[p].two;

        always_ff @(posedge clk) begin
            if (rst) fl_q[p] <= '0;
            else     fl_q[p] <= '{l0: cur[p].l0, l1: cur[p].l1, two: cur[p].two};
        end

        // R6: an answer only follows an access on the same port one cycle earlier
        p_rsp_follows_r6: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[p] |-> $past(acc_valid[p]));
    end

    pgm_lane_steer u_steer (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .clr_mask  (req_mask),
        .rsp_valid (rsp_valid),
        .fl        (fl_q),
        .rsp_data0 (rsp_data0),
        .rsp_data1 (rsp_data1),
        .result    (out_data),
        .resolved  (resolved)
    );

    // R2: active element addresses are word aligned when taken
    for (genvar e = 0; e < N_ELEM; e++) begin : g_align
        p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
            (accept && req_mask[e]) |-> (req_addr[e*ADDR_W +: WORD_LSB] == '0));
    end

    // R9: no access goes out while the request side is open
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_valid != '0) |-> !req_ready);

    // R5: the second port is only used alongside the first
    p_port_order_r5: assert property (@(posedge clk) disable iff (rst)
        acc_valid[1] |-> acc_valid[0]);

    // R8: completion is a single-cycle pulse
    p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8: completion only once every lane has been filled or zeroed
    p_done_resolved_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (resolved == '1));

endmodule

// File: tb/test_pair_gather_merge.sv
`timescale 1ns/1ps
module test_pair_gather_merge;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [511:0]  req_addr = '0;
    logic [7:0]    req_mask = '0;
    logic [1:0]    acc_valid;
    logic [113:0]  acc_block;
    logic [7:0]    acc_word0;
    logic [7:0]    acc_word1;
    logic [1:0]    acc_two;
    logic [1:0]    rsp_valid = '0;
    logic [127:0]  rsp_data0 = '0;
    logic [127:0]  rsp_data1 = '0;
    logic          out_valid;
    logic [511:0]  out_data;

    int checks = 0;
    int errors = 0;

    logic [56:0] e_blk [8];
    logic [3:0]  e_w0  [8];
    logic [3:0]  e_w1  [8];
    logic        e_two [8];
    int          n_exp;

    always #2.5 clk = ~clk;

    pair_gather_merge i_pair_gather_merge (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .acc_valid(acc_valid),
        .acc_block(acc_block), .acc_word0(acc_word0), .acc_word1(acc_word1),
        .acc_two(acc_two), .rsp_valid(rsp_valid), .rsp_data0(rsp_data0),
        .rsp_data1(rsp_data1), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        return {a[31:0] ^ 32'hC3A5_5A3C, a[63:32] + a[31:0] + 32'h1357_9BDF};
    endfunction

    // cache model: answers every access one cycle later
    always @(posedge clk) begin
        if (rst) rsp_valid <= '0;
        else begin
            rsp_valid <= acc_valid;
            for (int p = 0; p < 2; p++) begin
                rsp_data0[p*64 +: 64] <= mem_word({acc_block[p*57 +: 57], acc_word0[p*4 +: 4], 3'b000});
                rsp_data1[p*64 +: 64] <= mem_word({acc_block[p*57 +: 57], acc_word1[p*4 +: 4], 3'b000});
            end
        end
    end

    task automatic check(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic push(input logic [63:0] a, input logic [3:0] w1, input logic two);
        e_blk[n_exp] = a[63:7];
        e_w0[n_exp]  = a[6:3];
        e_w1[n_exp]  = w1;
        e_two[n_exp] = two;
        n_exp++;
    endtask

    task automatic build(input logic [511:0] ad, input logic [7:0] m);
        n_exp = 0;
        for (int k = 0; k < 4; k++) begin
            logic [63:0] ae, ao;
            ae = ad[(2*k)*64 +: 64];
            ao = ad[(2*k+1)*64 +: 64];
            if (m[2*k] && m[2*k+1]) begin
                if (ae[63:7] == ao[63:7]) push(ae, ao[6:3], 1'b1);
                else begin
                    push(ae, 4'd0, 1'b0);
                    push(ao, 4'd0, 1'b0);
                end
            end else if (m[2*k]) push(ae, 4'd0, 1'b0);
            else if (m[2*k+1]) push(ao, 4'd0, 1'b0);
        end
    endtask

    task automatic run(input logic [511:0] ad, input logic [7:0] m);
        int cyc, got, busy, exp_busy, exp_lat;
        logic order_ok, ready_ok;
        logic [511:0] held;
        build(ad, m);
        exp_busy = (n_exp + 1) / 2;
        exp_lat  = (n_exp == 0) ? 1 : exp_busy + 2;
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = ad;
        req_mask  = m;
        @(posedge clk);
        cyc = 0; got = 0; busy = 0; order_ok = 1'b1; ready_ok = 1'b1;
        while (cyc < 20) begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
            if (out_valid) break;
            if (req_ready) ready_ok = 1'b0;
            if (acc_valid[1] && !acc_valid[0]) order_ok = 1'b0;
            if (acc_valid != 2'b00) busy++;
            for (int p = 0; p < 2; p++) begin
                if (acc_valid[p]) begin
                    if (got >= n_exp) order_ok = 1'b0;
                    else begin
                        // R2 R3 R4: block, offsets and merge flag of each access in order
                        if (acc_block[p*57 +: 57] != e_blk[got]) order_ok = 1'b0;
                        if (acc_word0[p*4 +: 4] != e_w0[got]) order_ok = 1'b0;
                        if (acc_two[p] != e_two[got]) order_ok = 1'b0;
                        if (e_two[got] && acc_word1[p*4 +: 4] != e_w1[got]) order_ok = 1'b0;
                    end
                    got++;
                end
            end
        end
        check(order_ok, "R2/R3/R4 access contents", 64'(got), 64'(n_exp));
        check(got == n_exp, "R4 access count", 64'(got), 64'(n_exp));
        check(busy == exp_busy, "R5 busy cycles", 64'(busy), 64'(exp_busy));
        check(ready_ok, "R9 not ready while busy", 64'(ready_ok), 64'd1);
        check(out_valid && cyc == exp_lat, "R8 completion latency", 64'(cyc), 64'(exp_lat));
        for (int i = 0; i < 8; i++) begin
            logic [63:0] ev;
            ev = m[i] ? mem_word(ad[i*64 +: 64]) : 64'd0;
            if (m[i]) check(out_data[i*64 +: 64] == ev, "R6 lane data", out_data[i*64 +: 64], ev);
            else      check(out_data[i*64 +: 64] == ev, "R7 inactive lane zero", out_data[i*64 +: 64], ev);
        end
        held = out_data;
        @(negedge clk);
        check(!out_valid, "R8 single pulse", 64'(out_valid), 64'd0);
        check(out_data == held, "R8 result held", 64'(out_data == held), 64'd1);
    endtask

    function automatic logic [511:0] sweep_addr(input int pat, input int m);
        logic [511:0] ad;
        for (int k = 0; k < 4; k++) begin
            logic [63:0] be, ae, ao;
            be = 64'h0000_4000_0000_0000 + 64'(m) * 64'h2000 + 64'(k) * 64'h400;
            ae = be + 64'(((k * 3 + m) & 15) * 8);
            if (pat[k]) ao = be + 64'(((k * 5 + pat) & 15) * 8);
            else        ao = be + 64'h80 + 64'(((k * 5 + pat) & 15) * 8);
            ad[(2*k)*64 +: 64]   = ae;
            ad[(2*k+1)*64 +: 64] = ao;
        end
        return ad;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog expired: actual hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [511:0] ad;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(acc_valid == 2'b00, "R1 no access after reset", 64'(acc_valid), 64'd0);
        check(out_valid == 1'b0, "R1 no completion after reset", 64'(out_valid), 64'd0);

        // R2: all pairs share a block, fully merged
        for (int i = 0; i < 8; i++) ad[i*64 +: 64] = 64'h1000 + 64'(i) * 8;
        run(ad, 8'hFF);
        // R3: boundary, 0x..78 and 0x..80 straddle a block edge
        for (int k = 0; k < 4; k++) begin
            ad[(2*k)*64 +: 64]   = 64'h2078 + 64'(k) * 64'h100;
            ad[(2*k+1)*64 +: 64] = 64'h2080 + 64'(k) * 64'h100;
        end
        run(ad, 8'hFF);
        // R2: same block at both ends, offsets 0 and 15
        for (int k = 0; k < 4; k++) begin
            ad[(2*k)*64 +: 64]   = 64'h3000 + 64'(k) * 64'h80;
            ad[(2*k+1)*64 +: 64] = 64'h3078 + 64'(k) * 64'h80;
        end
        run(ad, 8'hFF);
        // R3: blocks differ only in the top address bit
        for (int k = 0; k < 4; k++) begin
            ad[(2*k)*64 +: 64]   = 64'h0000_0000_0000_5008 + 64'(k) * 64'h200;
            ad[(2*k+1)*64 +: 64] = 64'h8000_0000_0000_5010 + 64'(k) * 64'h200;
        end
        run(ad, 8'hFF);
        // R4: all lanes inactive
        run(ad, 8'h00);
        // R2: different pairs share one block, still one access per pair
        for (int i = 0; i < 8; i++) ad[i*64 +: 64] = 64'h7000 + 64'(7 - i) * 8;
        run(ad, 8'hFF);

        // near-exhaustive sweep: every mask with every per-pair merge pattern
        for (int pat = 0; pat < 16; pat++)
            for (int m = 0; m < 256; m++)
                run(sweep_addr(pat, m), 8'(m));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule